// File: doc/BRIEF.md
# Serial Audio Sample Receiver

This block turns a two-channel serial audio stream into parallel sample words. It runs as a slave. A bit clock, a word-select line and a data line come in from an external source. The block oversamples all three with its own system clock and finds the rising edges of the bit clock. At each rising edge it reads one data bit and the word-select level. The time between two word-select transitions is one half-frame, and each half-frame carries one sample for one channel.

Two framings are supported. In the first, data trails word-select by one bit clock. In the second, data starts together with word-select. The sample can sit at the start of the half-frame or at its end. The external source sets the half-frame length, so it may hold more or fewer bit clocks than the selected sample width. For each alignment, the block applies fixed rules for dropping extra bits, filling missing ones with zeros, or sign-extending.

When a word-select transition ends a half-frame, the finished sample appears on a right-justified output word, together with a channel tag and a one-cycle valid strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is active and after it is released, `valid_o`, `chan_o` and `sample_o` are all zero until the first sample is produced.
- R2: With `cfg_i2s_i` = 1, the data bit read on the first rising bit-clock edge after a word-select transition is the last bit of the previous half-frame. The new half-frame's first bit is read on the second rising edge.
- R3: With `cfg_i2s_i` = 0, the first bit of a half-frame is read on the first rising bit-clock edge after a word-select transition.
- R4: A rising bit-clock edge that shows a changed word-select level ends a half-frame. `valid_o` then pulses for exactly one cycle, on the (SYNC_STAGES+1)-th system-clock edge after the bit-clock rise is applied at the pins. `chan_o` gives the word-select level of the half-frame just ended (0 = left, 1 = right). The partial half-frame seen before the first transition after reset is never output. `sample_o` and `chan_o` hold their values between pulses.
- R5: `cfg_wsel_i` selects the sample width: 2'b00 = 8 bits, 2'b01 = 16 bits, 2'b10 or 2'b11 = 24 bits. The sample is right-justified in `sample_o`, and all bits above the width are zero.
- R6: With `cfg_right_i` = 0 and a half-frame longer than the width, the first bit is the sample MSB and every bit after the LSB position is dropped.
- R7: With `cfg_right_i` = 0 and a half-frame shorter than the width, the received bits fill the sample from the MSB down, and the missing low-order bits are zero.
- R8: With `cfg_right_i` = 1 and a half-frame longer than the width, the last bit is the sample LSB and every bit before the MSB position is dropped.
- R9: With `cfg_right_i` = 1 and a half-frame shorter than the width, the received bits form a two's-complement value that is sign-extended up to the width.
- R10: When the half-frame length equals the width, both alignment settings give the same sample: the first bit is the MSB and the last bit is the LSB.
- R11: The per-half-frame bit counter saturates, so half-frames longer than its range (more than 31 bits by default) still follow R6 and R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; oversamples the serial inputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial bit clock from the stream source |
| ws_i | input | 1 | Word select; low = left, high = right |
| sd_i | input | 1 | Serial data |
| cfg_i2s_i | input | 1 | 1 = one-bit-delayed framing, 0 = framing with no delay |
| cfg_right_i | input | 1 | 1 = sample ends the half-frame, 0 = sample starts it |
| cfg_wsel_i | input | 2 | Sample width select (see R5) |
| sample_o | output | MAX_W (24) | Completed sample, right-justified |
| chan_o | output | 1 | Channel of the completed sample |
| valid_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
Streams are sent with half-frame lengths equal to, longer than and shorter than each width, including lengths past the counter's range. This separates the drop rules, the zero fill and the sign extension between the two alignments. Both framings get the same bit pattern, so the one-bit offset is plainly visible. Short right-aligned frames start with alternating leading bits, which shows whether sign extension copies the right bit. The reserved width code and the equal-length runs show that the width decode and the alignment-independent case agree with the model.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        WSEL_8   = 2'b00,
        WSEL_16  = 2'b01,
        WSEL_24  = 2'b10,
        WSEL_RSV = 2'b11
    } wsel_e;

    // Number of sample bits for a width select code.
    function automatic int wsel_bits(input logic [1:0] sel);
        case (wsel_e'(sel))
            WSEL_8:  return 8;
            WSEL_16: return 16;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/srx_sync.sv
// Brings the serial pins into the system clock domain and flags bit-clock rises.
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic rise_o,
    output logic ws_o,
    output logic sd_o
);

    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] ws;
        logic [STAGES-1:0] sd;
        logic              sck_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.sck[0] = sck_i;
        sync_d.ws[0]  = ws_i;
        sync_d.sd[0]  = sd_i;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.sck[i] = sync_q.sck[i-1];
            sync_d.ws[i]  = sync_q.ws[i-1];
            sync_d.sd[i]  = sync_q.sd[i-1];
        end
        sync_d.sck_prev = sync_q.sck[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rise_o = sync_q.sck[STAGES-1] & ~sync_q.sck_prev;
    assign ws_o   = sync_q.ws[STAGES-1];
    assign sd_o   = sync_q.sd[STAGES-1];

endmodule

// File: rtl/srx_frame.sv
// Tracks word-select at each bit-clock rise and issues capture / emit commands.
module srx_frame (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rise_i,
    input  logic ws_i,
    input  logic i2s_i,
    output logic take_o,
    output logic emit_o,
    output logic restart_o,
    output logic seed_o,
    output logic chan_o
);

    typedef struct packed {
        logic known;
        logic active;
        logic ref_ws;
    } frame_t;

    frame_t frame_d, frame_q;

    always_comb begin
        frame_d   = frame_q;
        take_o    = 1'b0;
        emit_o    = 1'b0;
        restart_o = 1'b0;
        seed_o    = 1'b0;
        if (rise_i) begin
            if (!frame_q.known) begin
                frame_d.known  = 1'b1;
                frame_d.ref_ws = ws_i;
            end else if (ws_i != frame_q.ref_ws) begin
                // Delayed framing: this bit still closes the old half-frame.
                take_o         = i2s_i;
                emit_o         = frame_q.active;
                restart_o      = 1'b1;
                seed_o         = ~i2s_i;
                frame_d.ref_ws = ws_i;
                frame_d.active = 1'b1;
            end else begin
                take_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            frame_q <= '0;
        end else begin
            frame_q <= frame_d;
        end
    end

    assign chan_o = frame_q.ref_ws;

endmodule

// File: rtl/srx_collect.sv
// Keeps the first MAX_W bits (head) and the last MAX_W bits (tail) of a half-frame.
module srx_collect #(
    parameter int MAX_W = 24,
    parameter int CNT_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             take_i,
    input  logic             restart_i,
    input  logic             seed_i,
    input  logic             bit_i,
    output logic [MAX_W-1:0] head_o,
    output logic [MAX_W-1:0] tail_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [MAX_W-1:0] head;
        logic [MAX_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
    } col_t;

    col_t col_q, col_d, view;

    always_comb begin
        // View of the half-frame including the bit taken this cycle.
        view = col_q;
        if (take_i) begin
            for (int k = 0; k < MAX_W; k++) begin
                if (col_q.cnt == CNT_W'(k)) begin
                    view.head[MAX_W-1-k] = bit_i;
                end
            end
            view.tail = {col_q.tail[MAX_W-2:0], bit_i};
            if (col_q.cnt != CNT_MAX) begin
                view.cnt = col_q.cnt + 1'b1;
            end
        end

        col_d = view;
        if (restart_i) begin
            col_d = '0;
            if (seed_i) begin
                col_d.head[MAX_W-1] = bit_i;
                col_d.tail[0]       = bit_i;
                col_d.cnt           = CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            col_q <= '0;
        end else begin
            col_q <= col_d;
        end
    end

    assign head_o = view.head;
    assign tail_o = view.tail;
    assign cnt_o  = view.cnt;

endmodule

// File: rtl/srx_format.sv
// Turns captured bits into a right-justified sample per alignment and width.
module srx_format #(
    parameter int MAX_W = 24,
    parameter int CNT_W = 5
) (
    input  logic [MAX_W-1:0] head_i,
    input  logic [MAX_W-1:0] tail_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             right_i,
    input  logic [1:0]       wsel_i,
    output logic [MAX_W-1:0] sample_o
);
    import srx_pkg::*;

    int w;
    int n;
    logic sign;

    always_comb begin
        w = wsel_bits(wsel_i);
        if (w > MAX_W) begin
            w = MAX_W;
        end
        n        = int'(cnt_i);
        sign     = 1'b0;
        sample_o = '0;
        for (int j = 0; j < MAX_W; j++) begin
            if (j + 1 == n) begin
                sign = tail_i[j];
            end
        end
        for (int i = 0; i < MAX_W; i++) begin
            if (i < w) begin
                if (!right_i) begin
                    sample_o[i] = head_i[MAX_W - w + i];
                end else if (n >= w || i < n) begin
                    sample_o[i] = tail_i[i];
                end else begin
                    sample_o[i] = sign;
                end
            end
        end
    end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
    parameter int MAX_W       = 24,
    parameter int CNT_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sck_i,
    input  logic             ws_i,
    input  logic             sd_i,
    input  logic             cfg_i2s_i,
    input  logic             cfg_right_i,
    input  logic [1:0]       cfg_wsel_i,
    output logic [MAX_W-1:0] sample_o,
    output logic             chan_o,
    output logic             valid_o
);

    logic             rise, ws_s, sd_s;
    logic             take, emit, restart, seed, frame_chan;
    logic [MAX_W-1:0] head, tail, fmt;
    logic [CNT_W-1:0] cnt;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sck_i  (sck_i),
        .ws_i   (ws_i),
        .sd_i   (sd_i),
        .rise_o (rise),
        .ws_o   (ws_s),
        .sd_o   (sd_s)
    );

    srx_frame u_frame (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rise_i    (rise),
        .ws_i      (ws_s),
        .i2s_i     (cfg_i2s_i),
        .take_o    (take),
        .emit_o    (emit),
        .restart_o (restart),
        .seed_o    (seed),
        .chan_o    (frame_chan)
    );

    srx_collect #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_collect (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .take_i    (take),
        .restart_i (restart),
        .seed_i    (seed),
        .bit_i     (sd_s),
        .head_o    (head),
        .tail_o    (tail),
        .cnt_o     (cnt)
    );

    srx_format #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_format (
        .head_i   (head),
        .tail_i   (tail),
        .cnt_i    (cnt),
        .right_i  (cfg_right_i),
        .wsel_i   (cfg_wsel_i),
        .sample_o (fmt)
    );

    typedef struct packed {
        logic [MAX_W-1:0] sample;
        logic             chan;
        logic             valid;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = emit;
        if (emit) begin
            out_d.sample = fmt;
            out_d.chan   = frame_chan;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sample_o = out_q.sample;
    assign chan_o   = out_q.chan;
    assign valid_o  = out_q.valid;

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int MAX_W = 24
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       cfg_wsel_i,
    input logic [MAX_W-1:0] sample_o,
    input logic             chan_o,
    input logic             valid_o
);

    p_reset_clear_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (!valid_o && sample_o == '0 && !chan_o));

    p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    p_sample_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> $stable(sample_o));

    p_chan_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> $stable(chan_o));

    p_upper_zero8_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && $past(cfg_wsel_i) == 2'b00) |-> (sample_o[MAX_W-1:8] == '0));

    p_upper_zero16_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && $past(cfg_wsel_i) == 2'b01) |-> (sample_o[MAX_W-1:16] == '0));

endmodule

bind serial_audio_rx srx_checker #(.MAX_W(MAX_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_wsel_i (cfg_wsel_i),
    .sample_o   (sample_o),
    .chan_o     (chan_o),
    .valid_o    (valid_o)
);

// File: tb/serial_audio_rx_tb.sv
`timescale 1ns/1ps
module serial_audio_rx_tb;

    localparam int MAX_W = 24;
    localparam int LAT   = 3;   // SYNC_STAGES + 1
    localparam int PH    = 3;   // clocks per bit-clock phase
    localparam int LEAD  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, ws = 1'b1, sd = 1'b0;
    logic cfg_i2s = 1'b0, cfg_right = 1'b0;
    logic [1:0] cfg_wsel = 2'b01;
    logic [MAX_W-1:0] sample;
    logic chan, valid;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    int exp_val[$];
    int exp_chan[$];
    int exp_due[$];
    string exp_tag[$];

    logic fbits [0:3][0:63];
    logic ws_s [0:511];
    logic sd_s [0:511];
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_audio_rx u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sck_i       (sck),
        .ws_i        (ws),
        .sd_i        (sd),
        .cfg_i2s_i   (cfg_i2s),
        .cfg_right_i (cfg_right),
        .cfg_wsel_i  (cfg_wsel),
        .sample_o    (sample),
        .chan_o      (chan),
        .valid_o     (valid)
    );

    // Per-clock comparison against the model's queue of expected samples.
    always @(negedge clk) begin
        if (rst_n && valid) begin
            checks++;
            if (exp_val.size() == 0) begin
                errors++;
                $display("FAIL R4 unexpected valid at cycle %0d: got sample %h, expected no pulse", cyc, sample);
            end else begin
                if (exp_due[0] != cyc || int'(sample) != exp_val[0] || int'(chan) != exp_chan[0]) begin
                    errors++;
                    $display("FAIL %s/R4: cycle %0d sample %h chan %0d, expected cycle %0d sample %h chan %0d",
                             exp_tag[0], cyc, sample, chan, exp_due[0], exp_val[0], exp_chan[0]);
                end
                void'(exp_val.pop_front()); void'(exp_chan.pop_front());
                void'(exp_due.pop_front()); void'(exp_tag.pop_front());
            end
        end else if (exp_due.size() > 0 && cyc > exp_due[0]) begin
            checks++;
            errors++;
            $display("FAIL %s/R4: no valid pulse at cycle %0d, expected sample %h", exp_tag[0], exp_due[0], exp_val[0]);
            void'(exp_val.pop_front()); void'(exp_chan.pop_front());
            void'(exp_due.pop_front()); void'(exp_tag.pop_front());
        end
    end

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // Behavioural reference for one half-frame.
    function automatic int model(int h, int n, int w, logic right);
        int v = 0;
        if (!right) begin
            for (int i = 0; i < n && i < w; i++) if (fbits[h][i]) v += (1 << (w - 1 - i));
        end else if (n >= w) begin
            for (int j = 0; j < w; j++) if (fbits[h][n - w + j]) v += (1 << (w - 1 - j));
        end else if (n > 0) begin
            for (int j = 0; j < n; j++) if (fbits[h][j]) v += (1 << (n - 1 - j));
            if (fbits[h][0]) for (int i = n; i < w; i++) v += (1 << i);
        end
        return v;
    endfunction

    task automatic run(input logic i2s, input logic right, input logic [1:0] wsel,
                       input int n, input string tag);
        int w, total, nfr;
        nfr = 4;
        w = (wsel == 2'b00) ? 8 : (wsel == 2'b01) ? 16 : 24;
        exp_val.delete(); exp_chan.delete(); exp_due.delete(); exp_tag.delete();
        @(negedge clk);
        rst_n = 1'b0; sck = 1'b0; ws = 1'b1; sd = 1'b0;
        cfg_i2s = i2s; cfg_right = right; cfg_wsel = wsel;
        repeat (3) @(negedge clk);
        checks++;
        if (valid !== 1'b0 || sample !== '0 || chan !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset outputs valid %b chan %b sample %h, expected 0 0 0", valid, chan, sample);
        end
        rst_n = 1'b1;
        // Build the stream: lead-in, four half-frames, trailer.
        for (int h = 0; h < nfr; h++) begin
            for (int b = 0; b < n; b++) fbits[h][b] = next_bit();
            fbits[h][0] = h[0];
        end
        total = LEAD + nfr * n + 2;
        for (int k = 0; k < total; k++) begin
            int al;
            if (k < LEAD) begin
                ws_s[k] = 1'b1; al = 0;
            end else if (k < LEAD + nfr * n) begin
                ws_s[k] = ((k - LEAD) / n) % 2 == 1;
                al = 1;
            end else begin
                ws_s[k] = (nfr % 2) == 1; al = 0;
            end
            sd_s[k] = al ? fbits[(k - LEAD) / n][(k - LEAD) % n] : 1'b0;
        end
        if (i2s) begin
            for (int k = total - 1; k > 0; k--) sd_s[k] = sd_s[k-1];
            sd_s[0] = 1'b0;
        end
        // Drive it, queueing an expectation at each closing transition.
        for (int k = 0; k < total; k++) begin
            @(negedge clk);
            sck = 1'b0; ws = ws_s[k]; sd = sd_s[k];
            repeat (PH) @(negedge clk);
            sck = 1'b1;
            if (k >= LEAD + n && (k - LEAD) % n == 0 && (k - LEAD) / n <= nfr) begin
                int h = (k - LEAD) / n - 1;
                exp_val.push_back(model(h, n, w, right));
                exp_chan.push_back(h % 2);
                exp_due.push_back(cyc + LAT);
                exp_tag.push_back(tag);
            end
            repeat (PH - 1) @(negedge clk);
        end
        repeat (12) @(negedge clk);
        checks++;
        if (exp_val.size() != 0) begin
            errors++;
            $display("FAIL R4: %0d samples never produced, expected 0 outstanding", exp_val.size());
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        run(1'b1, 1'b0, 2'b01, 16, "R2_R10");  // delayed framing, exact length
        run(1'b0, 1'b0, 2'b01, 16, "R3_R10");  // no-delay framing, exact length
        run(1'b0, 1'b1, 2'b01, 16, "R3_R10");  // right alignment, exact length
        run(1'b1, 1'b0, 2'b00, 12, "R6");      // long frame, left
        run(1'b0, 1'b1, 2'b00, 12, "R8");      // long frame, right
        run(1'b0, 1'b0, 2'b10, 20, "R7");      // short frame, zero fill
        run(1'b1, 1'b1, 2'b10, 20, "R9");      // short frame, sign extend
        run(1'b0, 1'b1, 2'b01, 5,  "R9");      // very short, sign extend
        run(1'b1, 1'b0, 2'b01, 40, "R11_R6");  // counter saturation, left
        run(1'b0, 1'b1, 2'b01, 40, "R11_R8");  // counter saturation, right
        run(1'b1, 1'b0, 2'b11, 24, "R5");      // reserved code acts as 24 bits
        run(1'b0, 1'b1, 2'b00, 8,  "R5_R10");  // 8-bit exact
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule